// File: doc/BRIEF.md
# Dual-Space Internal Data Memory

This block is the internal data store of an 8-bit microcontroller core. It holds 256 bytes of RAM and fronts a special-function-register (SFR) port. Every access carries a one-byte address together with a flag that says whether the address is direct or indirect.

Addresses 00H–7FH always reach the lower RAM, in either mode. Addresses 80H–FFH have two meanings. An indirect access reaches a separate upper RAM bank. A direct access leaves the block on the SFR port. With both modes, one-byte addresses reach 384 storage locations.

Two more ports are mapped onto the lower RAM. A register port reads or writes working register n of the bank picked by the two status-word bank bits. A bit port reads, sets or clears single bits of the bit-addressable area. Bit addresses of 80H and above are forwarded to the SFR port as bit requests.

Top module: `dsm_top`

## Requirements
- R1: A byte access to an address 00H–7FH reaches the same RAM byte whether b_indirect is 0 or 1. b_rvalid rises in the cycle after the request, with the byte on b_rdata.
- R2: A byte access with b_indirect=1 and an address 80H–FFH reaches an upper RAM byte that is separate from the SFR space. sfr_req stays low during such an access.
- R3: For a byte access with b_indirect=0 and an address 80H–FFH:
  - in the same cycle, sfr_req=1, sfr_bit=0, sfr_addr is the address, and sfr_we and sfr_wdata follow b_we and b_wdata;
  - in the next cycle, b_rdata carries sfr_rdata;
  - no RAM byte changes.
- R4: A register-port access to register r_num of bank r_bank reaches RAM byte r_bank*8 + r_num. Its result appears on r_rdata with r_rvalid one cycle later.
- R5: A bit read at bit address k < 80H returns, on t_rdata one cycle later, bit (k & 7) of RAM byte 20H + (k >> 3).
- R6: A bit set (t_op=01) or bit clear (t_op=10) at k < 80H forces the addressed bit to 1 or 0, and leaves the other 7 bits of that byte unchanged. t_rdata returns the bit's value from before the operation. t_op=00 or 11 is a read.
- R7: A bit access at k ≥ 80H goes to the SFR port with sfr_bit=1 and sfr_addr=k:
  - set drives sfr_we=1 and sfr_wdata=01H;
  - clear drives sfr_we=1 and sfr_wdata=00H;
  - read drives sfr_we=0;
  - t_rdata one cycle later is sfr_rdata[0].
- R8: A byte or register write returns the byte's previous contents on its read-data output in the following cycle.
- R9: When requests arrive together, the byte port wins over the register port, and the register port wins over the bit port. A request that loses is dropped: it gets no valid response and has no effect on RAM.
- R10: After a synchronous reset (rst_n low at a clock edge), b_rvalid, r_rvalid and t_rvalid are 0. sfr_req is 0 while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| b_req | input | 1 | Byte access request |
| b_we | input | 1 | Byte access is a write |
| b_indirect | input | 1 | 1 = indirect mode, 0 = direct mode |
| b_addr | input | 8 | Byte address |
| b_wdata | input | 8 | Byte write data |
| b_rdata | output | 8 | Byte read data (old data on a write) |
| b_rvalid | output | 1 | Byte response valid |
| r_req | input | 1 | Register access request |
| r_we | input | 1 | Register access is a write |
| r_bank | input | 2 | Active bank (status-word bank bits) |
| r_num | input | 3 | Register number 0–7 |
| r_wdata | input | 8 | Register write data |
| r_rdata | output | 8 | Register read data |
| r_rvalid | output | 1 | Register response valid |
| t_req | input | 1 | Bit access request |
| t_op | input | 2 | 00/11 read, 01 set, 10 clear |
| t_addr | input | 8 | Bit address |
| t_rdata | output | 1 | Bit value (old value on set/clear) |
| t_rvalid | output | 1 | Bit response valid |
| sfr_req | output | 1 | SFR access request |
| sfr_we | output | 1 | SFR write |
| sfr_bit | output | 1 | SFR access is a bit access |
| sfr_addr | output | 8 | SFR byte or bit address |
| sfr_wdata | output | 8 | SFR write data (bit value in bit 0 for bit accesses) |
| sfr_rdata | input | 8 | SFR read data, valid in the cycle after sfr_req |

## Verification
The bench builds the block with its default parameters: four banks of eight registers, a 128-byte lower region, and the bit area based at 20H. These are the values under which bank-to-byte arithmetic and bit-to-byte arithmetic meet the real lower RAM and its SFR boundary. With them, the same 80H–FFH address can be sent down both paths in turn, and an upper RAM byte can be shown to survive a direct write that goes to the SFR side. With them, register bank 2 and bank 1 land on the bytes that byte reads observe, and bit addresses on either side of 80H go one to RAM and the other to the SFR port.

// File: rtl/dsm_pkg.sv
// Package dsm_pkg
// Shared types for the dual-space data memory.
// Assumes byte-wide data and one-byte addresses throughout.
package dsm_pkg;

    // Internal operation carried from the arbiter to the storage
    typedef enum logic [2:0] {
        OP_RD   = 3'd0,
        OP_WR   = 3'd1,
        OP_BRD  = 3'd2,
        OP_BSET = 3'd3,
        OP_BCLR = 3'd4
    } op_e;

    // Which port issued the granted request
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BYTE = 2'd1,
        SRC_REG  = 2'd2,
        SRC_BIT  = 2'd3
    } src_e;

    // One granted access per cycle
    typedef struct packed {
        logic       vld;
        src_e       src;
        op_e        op;
        logic       ind;
        logic [7:0] addr;
        logic [7:0] wdata;
    } cmd_t;

endpackage

// File: rtl/dsm_arb.sv
// Module dsm_arb
// Picks one request per cycle: the byte port first, then the register port,
// then the bit port. It turns the winner into a common command.
// Assumes the register bank and number fit below the lower RAM limit.
// A request that loses is not held; the requester must retry it.
module dsm_arb
    import dsm_pkg::*;
#(
    parameter int BANK_CNT  = 4,
    parameter int BANK_REGS = 8
) (
    input  logic                         b_req,
    input  logic                         b_we,
    input  logic                         b_indirect,
    input  logic [7:0]                   b_addr,
    input  logic [7:0]                   b_wdata,
    input  logic                         r_req,
    input  logic                         r_we,
    input  logic [$clog2(BANK_CNT)-1:0]  r_bank,
    input  logic [$clog2(BANK_REGS)-1:0] r_num,
    input  logic [7:0]                   r_wdata,
    input  logic                         t_req,
    input  logic [1:0]                   t_op,
    input  logic [7:0]                   t_addr,
    output cmd_t                         cmd
);

    logic [7:0] reg_addr;

    // Working register n of bank b sits at byte b*BANK_REGS + n
    always_comb begin
        reg_addr = 8'(r_bank) * 8'(BANK_REGS) + 8'(r_num);
    end

    // Fixed-priority selection of one request
    always_comb begin
        cmd = '0;
        if (b_req) begin
            cmd.vld   = 1'b1;
            cmd.src   = SRC_BYTE;
            cmd.op    = b_we ? OP_WR : OP_RD;
            cmd.ind   = b_indirect;
            cmd.addr  = b_addr;
            cmd.wdata = b_wdata;
        end else if (r_req) begin
            cmd.vld   = 1'b1;
            cmd.src   = SRC_REG;
            cmd.op    = r_we ? OP_WR : OP_RD;
            cmd.ind   = 1'b0;
            cmd.addr  = reg_addr;
            cmd.wdata = r_wdata;
        end else if (t_req) begin
            cmd.vld   = 1'b1;
            cmd.src   = SRC_BIT;
            cmd.ind   = 1'b0;
            cmd.addr  = t_addr;
            cmd.wdata = 8'h00;
            case (t_op)
                2'b01:   cmd.op = OP_BSET;
                2'b10:   cmd.op = OP_BCLR;
                default: cmd.op = OP_BRD;
            endcase
        end
    end

endmodule

// File: rtl/dsm_decode.sv
// Module dsm_decode
// Resolves a command address to either a RAM byte (and bit position) or the
// SFR port. At or above LOW_BYTES:
//   - an indirect byte access goes to upper RAM;
//   - a direct byte access goes to the SFR port;
//   - a bit access goes to the SFR port.
// Bit addresses below LOW_BYTES map into the area that starts at BITS_BASE.
// Assumes the RAM index equals the byte address for byte accesses.
module dsm_decode
    import dsm_pkg::*;
#(
    parameter int LOW_BYTES = 128,
    parameter int BITS_BASE = 32
) (
    input  logic       vld,
    input  op_e        op,
    input  logic       ind,
    input  logic [7:0] addr,
    output logic       ram_en,
    output logic       sfr_en,
    output logic       sfr_bit,
    output logic [7:0] ram_idx,
    output logic [2:0] bit_pos
);

    logic high;
    logic is_bit;

    // Classify the access
    always_comb begin
        high   = ({1'b0, addr} >= 9'(LOW_BYTES));
        is_bit = (op == OP_BRD) || (op == OP_BSET) || (op == OP_BCLR);
    end

    // Route to RAM or SFR and form the RAM location
    always_comb begin
        ram_en  = 1'b0;
        sfr_en  = 1'b0;
        sfr_bit = 1'b0;
        ram_idx = addr;
        bit_pos = addr[2:0];
        if (vld) begin
            if (is_bit) begin
                if (high) begin
                    sfr_en  = 1'b1;
                    sfr_bit = 1'b1;
                end else begin
                    ram_en  = 1'b1;
                    ram_idx = 8'(BITS_BASE) + {3'b000, addr[7:3]};
                end
            end else if (high && !ind) begin
                sfr_en = 1'b1;
            end else begin
                ram_en = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsm_ram.sv
// Module dsm_ram
// Byte storage with one-cycle registered reads. It supports a byte write and
// a single-bit set or clear done as a read-modify-write within one cycle.
// The read path always returns the contents from before the write.
// Contents are not reset; only the read registers are.
module dsm_ram
    import dsm_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  op_e              op,
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       pos,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_byte,
    output logic             rd_bit
);

    logic [7:0] mem [DEPTH];

    // Update storage for byte writes and bit set/clear
    always_ff @(posedge clk) begin
        if (en) begin
            case (op)
                OP_WR:   mem[idx]      <= wdata;
                OP_BSET: mem[idx][pos] <= 1'b1;
                OP_BCLR: mem[idx][pos] <= 1'b0;
                default: ;
            endcase
        end
    end

    // Register the old byte and old bit for the response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte <= 8'h00;
            rd_bit  <= 1'b0;
        end else if (en) begin
            rd_byte <= mem[idx];
            rd_bit  <= mem[idx][pos];
        end
    end

    // R6
    bit_set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_BSET) |=>
            (mem[$past(idx)] == ($past(mem[idx]) | (8'd1 << $past(pos)))));

    // R6
    bit_clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_BCLR) |=>
            (mem[$past(idx)] == ($past(mem[idx]) & ~(8'd1 << $past(pos)))));

    // R8
    old_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == OP_WR) |=> (rd_byte == $past(mem[idx])));

endmodule

// File: rtl/dsm_top.sv
// Module dsm_top
// Dual-space internal data memory. It arbitrates three access ports and
// decodes the winner onto RAM or the SFR port. It returns the result one
// cycle later on the port that asked.
// Assumes the SFR side answers with sfr_rdata in the cycle after sfr_req.
module dsm_top
    import dsm_pkg::*;
#(
    parameter int BANK_CNT  = 4,
    parameter int BANK_REGS = 8,
    parameter int LOW_BYTES = 128,
    parameter int BITS_BASE = 32,
    localparam int DEPTH    = 256,
    localparam int BANK_W   = $clog2(BANK_CNT),
    localparam int NUM_W    = $clog2(BANK_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              b_req,
    input  logic              b_we,
    input  logic              b_indirect,
    input  logic [7:0]        b_addr,
    input  logic [7:0]        b_wdata,
    output logic [7:0]        b_rdata,
    output logic              b_rvalid,
    input  logic              r_req,
    input  logic              r_we,
    input  logic [BANK_W-1:0] r_bank,
    input  logic [NUM_W-1:0]  r_num,
    input  logic [7:0]        r_wdata,
    output logic [7:0]        r_rdata,
    output logic              r_rvalid,
    input  logic              t_req,
    input  logic [1:0]        t_op,
    input  logic [7:0]        t_addr,
    output logic              t_rdata,
    output logic              t_rvalid,
    output logic              sfr_req,
    output logic              sfr_we,
    output logic              sfr_bit,
    output logic [7:0]        sfr_addr,
    output logic [7:0]        sfr_wdata,
    input  logic [7:0]        sfr_rdata
);

    cmd_t       cmd;
    logic       ram_en;
    logic       sfr_en;
    logic       sfr_bit_d;
    logic [7:0] ram_idx;
    logic [2:0] bit_pos;
    logic [7:0] ram_byte;
    logic       ram_bit;
    src_e       src_q;
    logic       sfr_q;

    dsm_arb #(
        .BANK_CNT  (BANK_CNT),
        .BANK_REGS (BANK_REGS)
    ) arb_i (
        .b_req      (b_req),
        .b_we       (b_we),
        .b_indirect (b_indirect),
        .b_addr     (b_addr),
        .b_wdata    (b_wdata),
        .r_req      (r_req),
        .r_we       (r_we),
        .r_bank     (r_bank),
        .r_num      (r_num),
        .r_wdata    (r_wdata),
        .t_req      (t_req),
        .t_op       (t_op),
        .t_addr     (t_addr),
        .cmd        (cmd)
    );

    dsm_decode #(
        .LOW_BYTES (LOW_BYTES),
        .BITS_BASE (BITS_BASE)
    ) dec_i (
        .vld     (cmd.vld),
        .op      (cmd.op),
        .ind     (cmd.ind),
        .addr    (cmd.addr),
        .ram_en  (ram_en),
        .sfr_en  (sfr_en),
        .sfr_bit (sfr_bit_d),
        .ram_idx (ram_idx),
        .bit_pos (bit_pos)
    );

    dsm_ram #(
        .DEPTH (DEPTH)
    ) ram_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ram_en),
        .op      (cmd.op),
        .idx     (ram_idx),
        .pos     (bit_pos),
        .wdata   (cmd.wdata),
        .rd_byte (ram_byte),
        .rd_bit  (ram_bit)
    );

    // Drive the SFR request from the decoded command
    always_comb begin
        sfr_req   = sfr_en;
        sfr_bit   = sfr_bit_d;
        sfr_addr  = cmd.addr;
        sfr_we    = sfr_en && (cmd.op == OP_WR || cmd.op == OP_BSET ||
                               cmd.op == OP_BCLR);
        sfr_wdata = sfr_bit_d ? {7'b0000000, (cmd.op == OP_BSET)} : cmd.wdata;
    end

    // Remember who asked and whether the answer comes from the SFR side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_NONE;
            sfr_q <= 1'b0;
        end else begin
            src_q <= cmd.vld ? cmd.src : SRC_NONE;
            sfr_q <= sfr_en;
        end
    end

    // Steer the response to the requesting port
    always_comb begin
        b_rvalid = (src_q == SRC_BYTE);
        r_rvalid = (src_q == SRC_REG);
        t_rvalid = (src_q == SRC_BIT);
        b_rdata  = sfr_q ? sfr_rdata : ram_byte;
        r_rdata  = ram_byte;
        t_rdata  = sfr_q ? sfr_rdata[0] : ram_bit;
    end

    // R2
    upper_not_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && b_indirect) |-> !sfr_req);

    // R3
    direct_high_sfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !b_indirect && b_addr[7]) |->
            (sfr_req && !sfr_bit && sfr_addr == b_addr && sfr_we == b_we));

    // R9
    byte_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_req |=> (b_rvalid && !r_rvalid && !t_rvalid));

    // R9
    reg_over_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_req && !b_req) |=> (r_rvalid && !t_rvalid));

    // R7
    sfr_bit_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_req && !b_req && !r_req && t_addr[7]) |->
            (sfr_req && sfr_bit && sfr_addr == t_addr));

endmodule

// File: tb/dsm_top_tb_top.sv
`timescale 1ns/1ps
module dsm_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       b_req, b_we, b_indirect;
    logic [7:0] b_addr, b_wdata, b_rdata;
    logic       b_rvalid;
    logic       r_req, r_we;
    logic [1:0] r_bank;
    logic [2:0] r_num;
    logic [7:0] r_wdata, r_rdata;
    logic       r_rvalid;
    logic       t_req;
    logic [1:0] t_op;
    logic [7:0] t_addr;
    logic       t_rdata, t_rvalid;
    logic       sfr_req, sfr_we, sfr_bit;
    logic [7:0] sfr_addr, sfr_wdata;
    logic [7:0] sfr_rdata = 8'h00;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [256];

    // Values captured on the SFR port during the last request cycle
    logic       c_req, c_we, c_bit;
    logic [7:0] c_addr, c_wdata;

    always #5 clk = ~clk;

    dsm_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .b_req(b_req), .b_we(b_we), .b_indirect(b_indirect), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid),
        .r_req(r_req), .r_we(r_we), .r_bank(r_bank), .r_num(r_num),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
        .t_req(t_req), .t_op(t_op), .t_addr(t_addr), .t_rdata(t_rdata),
        .t_rvalid(t_rvalid),
        .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_bit(sfr_bit),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // SFR stand-in: answers each request with its address XOR 5AH a cycle later
    always @(posedge clk) if (sfr_req) sfr_rdata <= sfr_addr ^ 8'h5A;

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic capture_sfr();
        c_req = sfr_req; c_we = sfr_we; c_bit = sfr_bit;
        c_addr = sfr_addr; c_wdata = sfr_wdata;
    endtask

    task automatic do_byte(input logic we, input logic ind, input logic [7:0] a,
                           input logic [7:0] d, output logic [7:0] q, output logic v);
        @(negedge clk);
        b_req = 1'b1; b_we = we; b_indirect = ind; b_addr = a; b_wdata = d;
        #1 capture_sfr();
        @(posedge clk); #1;
        q = b_rdata; v = b_rvalid;
        b_req = 1'b0;
    endtask

    task automatic do_reg(input logic we, input logic [1:0] bk, input logic [2:0] n,
                          input logic [7:0] d, output logic [7:0] q, output logic v);
        @(negedge clk);
        r_req = 1'b1; r_we = we; r_bank = bk; r_num = n; r_wdata = d;
        @(posedge clk); #1;
        q = r_rdata; v = r_rvalid;
        r_req = 1'b0;
    endtask

    task automatic do_bit(input logic [1:0] op, input logic [7:0] k,
                          output logic q, output logic v);
        @(negedge clk);
        t_req = 1'b1; t_op = op; t_addr = k;
        #1 capture_sfr();
        @(posedge clk); #1;
        q = t_rdata; v = t_rvalid;
        t_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 b_rvalid", {7'b0, b_rvalid}, 8'h00);
        check("R10 r_rvalid", {7'b0, r_rvalid}, 8'h00);
        check("R10 t_rvalid", {7'b0, t_rvalid}, 8'h00);
        check("R10 sfr_req",  {7'b0, sfr_req},  8'h00);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_fill();
        logic [7:0] q; logic v;
        for (int i = 0; i < 256; i++) begin
            do_byte(1'b1, 1'b1, 8'(i), 8'(i) ^ 8'hC3, q, v);
            model[i] = 8'(i) ^ 8'hC3;
        end
    endtask

    task automatic t_lower();
        logic [7:0] q; logic v;
        do_byte(1'b1, 1'b0, 8'h50, 8'hA7, q, v); model[8'h50] = 8'hA7;
        do_byte(1'b0, 1'b1, 8'h50, 8'h00, q, v);
        check("R1 indirect sees direct write", q, 8'hA7);
        check("R1 rvalid", {7'b0, v}, 8'h01);
        do_byte(1'b0, 1'b0, 8'h7F, 8'h00, q, v);
        check("R1 direct read 7F", q, model[8'h7F]);
    endtask

    task automatic t_upper();
        logic [7:0] q; logic v;
        do_byte(1'b1, 1'b1, 8'h90, 8'h3C, q, v); model[8'h90] = 8'h3C;
        check("R2 no sfr_req on indirect", {7'b0, c_req}, 8'h00);
        do_byte(1'b1, 1'b0, 8'h90, 8'hEE, q, v);
        do_byte(1'b0, 1'b1, 8'h90, 8'h00, q, v);
        check("R2 upper byte kept after direct write", q, 8'h3C);
        check("R2 no sfr_req on indirect read", {7'b0, c_req}, 8'h00);
        do_byte(1'b0, 1'b1, 8'hFF, 8'h00, q, v);
        check("R2 upper FF", q, model[8'hFF]);
    endtask

    task automatic t_sfr();
        logic [7:0] q; logic v;
        do_byte(1'b1, 1'b0, 8'hA5, 8'h19, q, v);
        check("R3 sfr_req", {7'b0, c_req}, 8'h01);
        check("R3 sfr_we", {7'b0, c_we}, 8'h01);
        check("R3 sfr_bit", {7'b0, c_bit}, 8'h00);
        check("R3 sfr_addr", c_addr, 8'hA5);
        check("R3 sfr_wdata", c_wdata, 8'h19);
        do_byte(1'b0, 1'b0, 8'h83, 8'h00, q, v);
        check("R3 sfr read data", q, 8'h83 ^ 8'h5A);
        check("R3 sfr read we", {7'b0, c_we}, 8'h00);
        do_byte(1'b0, 1'b1, 8'hA5, 8'h00, q, v);
        check("R3 upper A5 untouched", q, model[8'hA5]);
    endtask

    task automatic t_regs();
        logic [7:0] q; logic v;
        do_reg(1'b1, 2'd2, 3'd3, 8'h6B, q, v); model[8'h13] = 8'h6B;
        check("R4 reg write rvalid", {7'b0, v}, 8'h01);
        do_byte(1'b0, 1'b0, 8'h13, 8'h00, q, v);
        check("R4 bank2 R3 at 13H", q, 8'h6B);
        do_byte(1'b1, 1'b0, 8'h0F, 8'hD2, q, v); model[8'h0F] = 8'hD2;
        do_reg(1'b0, 2'd1, 3'd7, 8'h00, q, v);
        check("R4 bank1 R7 reads 0FH", q, 8'hD2);
        do_reg(1'b0, 2'd3, 3'd0, 8'h00, q, v);
        check("R4 bank3 R0 reads 18H", q, model[8'h18]);
    endtask

    task automatic t_bits();
        logic q; logic v; logic [7:0] bq; logic bv;
        logic [7:0] k;
        logic [7:0] byte_i;
        k = 8'h2B; byte_i = 8'h20 + 8'(k >> 3);
        do_bit(2'b00, k, q, v);
        check("R5 bit read", {7'b0, q}, {7'b0, model[byte_i][k[2:0]]});
        check("R5 bit rvalid", {7'b0, v}, 8'h01);
        do_bit(2'b01, k, q, v);
        check("R6 set returns old bit", {7'b0, q}, {7'b0, model[byte_i][k[2:0]]});
        model[byte_i][k[2:0]] = 1'b1;
        do_byte(1'b0, 1'b0, byte_i, 8'h00, bq, bv);
        check("R6 byte after set", bq, model[byte_i]);
        k = 8'h29;
        do_bit(2'b10, k, q, v);
        check("R6 clear returns old bit", {7'b0, q}, {7'b0, model[byte_i][k[2:0]]});
        model[byte_i][k[2:0]] = 1'b0;
        do_byte(1'b0, 1'b0, byte_i, 8'h00, bq, bv);
        check("R6 byte after clear", bq, model[byte_i]);
        k = 8'h7F; byte_i = 8'h2F;
        do_bit(2'b11, k, q, v);
        check("R6 op 11 reads bit 7FH", {7'b0, q}, {7'b0, model[byte_i][7]});
        do_byte(1'b0, 1'b0, byte_i, 8'h00, bq, bv);
        check("R6 op 11 leaves byte", bq, model[byte_i]);
    endtask

    task automatic t_sfrbit();
        logic q; logic v; logic [7:0] bq; logic bv;
        do_bit(2'b01, 8'h93, q, v);
        check("R7 set sfr_bit", {7'b0, c_bit}, 8'h01);
        check("R7 set sfr_addr", c_addr, 8'h93);
        check("R7 set we", {7'b0, c_we}, 8'h01);
        check("R7 set wdata", c_wdata, 8'h01);
        check("R7 set returns sfr bit", {7'b0, q}, {7'b0, (8'h93 ^ 8'h5A) & 8'h01});
        do_bit(2'b10, 8'hE0, q, v);
        check("R7 clear we", {7'b0, c_we}, 8'h01);
        check("R7 clear wdata", c_wdata, 8'h00);
        do_bit(2'b00, 8'hE0, q, v);
        check("R7 read we", {7'b0, c_we}, 8'h00);
        check("R7 read bit", {7'b0, q}, {7'b0, (8'hE0 ^ 8'h5A) & 8'h01});
        do_byte(1'b0, 1'b0, 8'h32, 8'h00, bq, bv);
        check("R7 RAM 32H untouched", bq, model[8'h32]);
    endtask

    task automatic t_rdw();
        logic [7:0] q; logic v;
        do_byte(1'b1, 1'b0, 8'h44, 8'h81, q, v);
        check("R8 byte write returns old", q, model[8'h44]);
        model[8'h44] = 8'h81;
        do_reg(1'b1, 2'd0, 3'd5, 8'h12, q, v);
        check("R8 reg write returns old", q, model[8'h05]);
        model[8'h05] = 8'h12;
    endtask

    task automatic t_prio();
        logic [7:0] q; logic v;
        @(negedge clk);
        b_req = 1'b1; b_we = 1'b0; b_indirect = 1'b0; b_addr = 8'h40;
        r_req = 1'b1; r_we = 1'b1; r_bank = 2'd0; r_num = 3'd1; r_wdata = 8'h77;
        t_req = 1'b1; t_op = 2'b01; t_addr = 8'h00;
        @(posedge clk); #1;
        check("R9 byte wins data", b_rdata, model[8'h40]);
        check("R9 r_rvalid low", {7'b0, r_rvalid}, 8'h00);
        check("R9 t_rvalid low", {7'b0, t_rvalid}, 8'h00);
        b_req = 1'b0;
        @(posedge clk); #1;
        check("R9 reg beats bit", {6'b0, r_rvalid, t_rvalid}, 8'h02);
        model[8'h01] = 8'h77;
        r_req = 1'b0; t_req = 1'b0;
        do_byte(1'b0, 1'b0, 8'h20, 8'h00, q, v);
        check("R9 dropped bit set had no effect", q, model[8'h20]);
        do_byte(1'b0, 1'b0, 8'h01, 8'h00, q, v);
        check("R9 reg write after byte", q, 8'h77);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        b_req = 0; b_we = 0; b_indirect = 0; b_addr = 0; b_wdata = 0;
        r_req = 0; r_we = 0; r_bank = 0; r_num = 0; r_wdata = 0;
        t_req = 0; t_op = 0; t_addr = 0;
        t_reset();
        t_fill();
        t_lower();
        t_upper();
        t_sfr();
        t_regs();
        t_bits();
        t_sfrbit();
        t_rdw();
        t_prio();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule